// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar

This block keeps wall-clock time and calendar date as BCD-coded registers. It advances one second for each pulse on a once-per-second tick input. The fields are seconds, minutes, hours, day of month, month, two-digit year and day of week. Month lengths are handled automatically, and February gains its 29th day whenever the year count is divisible by four. That rule is exact for the years 2000 to 2099, which is the span the block covers.

The hour field has two encodings, selected by a format input: a 24-hour count, or a 12-hour count with an afternoon flag. A host loads any single field through a one-cycle write port. All fields are exposed together, and every field changes on the same clock edge, so the outputs read in any one cycle always form a consistent snapshot. Two one-cycle strobes tell downstream logic when a new hour and a new day begin.

A tick is first captured in a pending flag and applied on a later cycle. Host writes therefore never collide with an increment in the same cycle.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Seconds and minutes count BCD 00 to 59. An advance from second 59 sets seconds to 00 and steps the minutes. Minute 59 wraps to 00 and steps the hour.
- R2: With the format input low, the hour counts BCD 00 to 23. Stepping past 23 gives 00 and advances the date.
- R3: With the format input high, the hour field holds bit 5 as the afternoon flag (1 = PM) and bits 4:0 as BCD 12, 01 to 11. Stepping from 11 to 12 toggles the flag. Stepping from 11 PM to 12 AM also advances the date. Stepping from 12 gives 01 with the flag unchanged.
- R4: Months 04, 06, 09 and 11 have 30 days, and all months other than February have 31. An advance past the last day sets the date to 01 and steps the month.
- R5: February has 29 days when the binary value of the year field is divisible by four, and 28 days otherwise.
- R6: Stepping past month 12 gives 01 and steps the year. Year 99 wraps to 00.
- R7: Day of week counts 0 to 6, steps whenever the date advances, and wraps from 6 to 0.
- R8: A tick sampled at one clock edge takes effect on the following edge, two edges after it was driven. Without a tick the fields hold.
- R9: A write with field select 0=seconds, 1=minutes, 2=hours, 3=day of week, 4=date, 5=month, 6=year loads that field at the next edge. While a write is present no advance occurs. A pending tick is applied in the first cycle that has no write.
- R10: A seconds write discards any pending tick, including one arriving in the same cycle.
- R11: The hour strobe is high for exactly the one cycle in which minutes have just wrapped from 59 to 00. The date strobe is high for the one cycle in which the date has just advanced.
- R12: Reset gives 00:00:00, date 01, month 01, year 00, day of week 0, and both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| fmt_12h | input | 1 | 1 = 12-hour hour encoding, 0 = 24-hour |
| wr_en | input | 1 | Host write strobe |
| wr_field | input | 3 | Field select for the write |
| wr_data | input | 8 | BCD value to load |
| rd_sec | output | 8 | Seconds, BCD |
| rd_min | output | 8 | Minutes, BCD |
| rd_hour | output | 8 | Hour, BCD in the selected encoding |
| rd_date | output | 8 | Day of month, BCD |
| rd_month | output | 8 | Month, BCD |
| rd_year | output | 8 | Year 00 to 99, BCD |
| rd_dow | output | 8 | Day of week 0 to 6 |
| hour_rolled | output | 1 | One-cycle new-hour strobe |
| date_rolled | output | 1 | One-cycle new-day strobe |

## Verification
The assertions assume the following about the inputs:
- Every host write carries a legal BCD value for its field, and the written date fits the current month.
- Ticks are far enough apart that no more than one is pending at a time.
- The hour field is rewritten whenever the format input changes.

The stimulus keeps within these limits. Random writes draw only legal values. Before a month or year write that would shorten the current month, the bench first lowers the date. Each format change is followed at once by an hour write in the new encoding. Ticks are always separated by several idle cycles.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 7;
  localparam int SEL_W      = $clog2(NUM_FIELDS);

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DOW   = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6
  } field_e;

  // increment a two-digit BCD value, no wrap check
  function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(input logic [FIELD_W-1:0] yr);
    logic [6:0] bin;
    bin = {3'b0, yr[7:4]} * 7'd10 + {3'b0, yr[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [FIELD_W-1:0] month_len(input logic [FIELD_W-1:0] mon,
                                                   input logic [FIELD_W-1:0] yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] hour_next(input logic [FIELD_W-1:0] h,
                                                   input logic mode12);
    logic [7:0] d;
    if (!mode12) return (h == 8'h23) ? 8'h00 : bcd_inc(h);
    d = bcd_inc({3'b0, h[4:0]});
    if (h[4:0] == 5'h12) return {2'b0, h[5], 5'h01};
    if (h[4:0] == 5'h11) return {2'b0, ~h[5], 5'h12};
    return {2'b0, h[5], d[4:0]};
  endfunction

  function automatic logic hour_day_end(input logic [FIELD_W-1:0] h, input logic mode12);
    if (!mode12) return h == 8'h23;
    return h[5] && (h[4:0] == 5'h11);
  endfunction
endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               mode12,
  input  logic               wr_sec,
  input  logic               wr_min,
  input  logic               wr_hour,
  input  logic [FIELD_W-1:0] wr_data,
  output logic [FIELD_W-1:0] sec_q,
  output logic [FIELD_W-1:0] min_q,
  output logic [FIELD_W-1:0] hour_q,
  output logic               min_wrap,
  output logic               day_carry
);
  logic sec_wrap;

  assign sec_wrap  = step && (sec_q == 8'h59);
  assign min_wrap  = sec_wrap && (min_q == 8'h59);
  assign day_carry = min_wrap && hour_day_end(hour_q, mode12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
    end else begin
      if (wr_sec)        sec_q <= wr_data;
      else if (step)     sec_q <= sec_wrap ? 8'h00 : bcd_inc(sec_q);
      if (wr_min)        min_q <= wr_data;
      else if (sec_wrap) min_q <= min_wrap ? 8'h00 : bcd_inc(min_q);
      if (wr_hour)       hour_q <= wr_data;
      else if (min_wrap) hour_q <= hour_next(hour_q, mode12);
    end
  end

  a_r1_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_sec) |=> $stable(sec_q));
  a_r9_sec_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sec |=> sec_q == $past(wr_data));
  a_r3_pm_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (min_wrap && mode12 && hour_q[4:0] == 5'h11) |=> hour_q[5] != $past(hour_q[5]));
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               wr_dow,
  input  logic               wr_date,
  input  logic               wr_month,
  input  logic               wr_year,
  input  logic [FIELD_W-1:0] wr_data,
  output logic [FIELD_W-1:0] dow_q,
  output logic [FIELD_W-1:0] date_q,
  output logic [FIELD_W-1:0] month_q,
  output logic [FIELD_W-1:0] year_q
);
  localparam logic [FIELD_W-1:0] LAST_DOW = 8'h06;
  logic mon_end, yr_end;

  assign mon_end = step && (date_q == month_len(month_q, year_q));
  assign yr_end  = mon_end && (month_q == 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dow_q   <= '0;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= '0;
    end else begin
      if (wr_dow)        dow_q <= wr_data;
      else if (step)     dow_q <= (dow_q == LAST_DOW) ? 8'h00 : dow_q + 8'h01;
      if (wr_date)       date_q <= wr_data;
      else if (step)     date_q <= mon_end ? 8'h01 : bcd_inc(date_q);
      if (wr_month)      month_q <= wr_data;
      else if (mon_end)  month_q <= yr_end ? 8'h01 : bcd_inc(month_q);
      if (wr_year)       year_q <= wr_data;
      else if (yr_end)   year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  a_r7_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_dow && dow_q == LAST_DOW) |=> dow_q == 8'h00);
  a_r4_month_start: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_end && !wr_date) |=> date_q == 8'h01);
  a_r6_year_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!yr_end && !wr_year) |=> $stable(year_q));
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_1hz,
  input  logic               fmt_12h,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_field,
  input  logic [FIELD_W-1:0] wr_data,
  output logic [FIELD_W-1:0] rd_sec,
  output logic [FIELD_W-1:0] rd_min,
  output logic [FIELD_W-1:0] rd_hour,
  output logic [FIELD_W-1:0] rd_date,
  output logic [FIELD_W-1:0] rd_month,
  output logic [FIELD_W-1:0] rd_year,
  output logic [FIELD_W-1:0] rd_dow,
  output logic               hour_rolled,
  output logic               date_rolled
);
  logic [NUM_FIELDS-1:0] wr_hit;
  logic pend_q, advance, min_wrap, day_carry;
  logic hr_strobe_q, dt_strobe_q;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_wr_dec
    assign wr_hit[i] = wr_en && (wr_field == SEL_W'(i));
  end

  // a write always wins the cycle; the tick waits in pend_q
  assign advance = pend_q && !wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      hr_strobe_q <= 1'b0;
      dt_strobe_q <= 1'b0;
    end else begin
      if (wr_hit[FLD_SEC]) pend_q <= 1'b0;
      else if (tick_1hz)   pend_q <= 1'b1;
      else if (advance)    pend_q <= 1'b0;
      hr_strobe_q <= min_wrap;
      dt_strobe_q <= day_carry;
    end
  end

  rtc_time_chain i_time (
    .clk, .rst_n, .step(advance), .mode12(fmt_12h),
    .wr_sec(wr_hit[FLD_SEC]), .wr_min(wr_hit[FLD_MIN]), .wr_hour(wr_hit[FLD_HOUR]),
    .wr_data, .sec_q(rd_sec), .min_q(rd_min), .hour_q(rd_hour),
    .min_wrap, .day_carry
  );

  rtc_date_chain i_date (
    .clk, .rst_n, .step(day_carry),
    .wr_dow(wr_hit[FLD_DOW]), .wr_date(wr_hit[FLD_DATE]),
    .wr_month(wr_hit[FLD_MONTH]), .wr_year(wr_hit[FLD_YEAR]),
    .wr_data, .dow_q(rd_dow), .date_q(rd_date), .month_q(rd_month), .year_q(rd_year)
  );

  assign hour_rolled = hr_strobe_q;
  assign date_rolled = dt_strobe_q;

  a_r10_sec_write_drops: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[FLD_SEC] |=> !pend_q);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !wr_en) |=> $stable(rd_sec));
  a_r11_hour_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    hour_rolled |-> (rd_min == 8'h00 && rd_sec == 8'h00));
  a_r11_hour_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hour_rolled |=> !hour_rolled);
  a_r11_date_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    date_rolled |-> (rd_hour == 8'h00 || rd_hour == 8'h12));
endmodule

// File: tb/test_rtc_bcd_calendar.sv
`timescale 1ns/1ps
module test_rtc_bcd_calendar;
  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, fmt_12h = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_field = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_sec, rd_min, rd_hour, rd_date, rd_month, rd_year, rd_dow;
  logic hour_rolled, date_rolled;

  int n_chk = 0, n_err = 0;
  int m_sec, m_min, m_hr, m_date, m_mon, m_yr, m_dow;
  bit m12, e_hr_roll, e_dt_roll;

  always #4 clk = ~clk;

  rtc_bcd_calendar i_rtc_bcd_calendar (
    .clk, .rst_n, .tick_1hz, .fmt_12h, .wr_en, .wr_field, .wr_data,
    .rd_sec, .rd_min, .rd_hour, .rd_date, .rd_month, .rd_year, .rd_dow,
    .hour_rolled, .date_rolled
  );

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic logic [7:0] enc_hour(input int hr, input bit twelve);
    int h;
    logic [7:0] b;
    if (!twelve) return bcd(hr);
    h = hr % 12;
    if (h == 0) h = 12;
    b = bcd(h);
    return {2'b00, (hr >= 12), b[4:0]};
  endfunction

  function automatic int days_in(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    e_hr_roll = 0; e_dt_roll = 0;
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++; e_hr_roll = 1;
        if (m_hr == 24) begin
          m_hr = 0; e_dt_roll = 1;
          m_dow = (m_dow + 1) % 7;
          m_date++;
          if (m_date > days_in(m_mon, m_yr)) begin
            m_date = 1; m_mon++;
            if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "sec", rd_sec, bcd(m_sec));
    chk(req, "min", rd_min, bcd(m_min));
    chk(req, "hour", rd_hour, enc_hour(m_hr, m12));
    chk(req, "date", rd_date, bcd(m_date));
    chk(req, "month", rd_month, bcd(m_mon));
    chk(req, "year", rd_year, bcd(m_yr));
    chk(req, "dow", rd_dow, bcd(m_dow));
    chk(req, "hour_rolled", {7'b0, hour_rolled}, {7'b0, e_hr_roll});
    chk(req, "date_rolled", {7'b0, date_rolled}, {7'b0, e_dt_roll});
  endtask

  // called at a negedge, returns at a negedge
  task automatic do_tick(input string req);
    tick_1hz = 1'b1;
    @(posedge clk); @(negedge clk);
    tick_1hz = 1'b0;
    @(posedge clk); @(negedge clk);
    model_tick();
    check_all(req);
  endtask

  task automatic put_field(input int fld, input int val);
    case (fld)
      0: m_sec = val;  1: m_min = val;  2: m_hr = val;  3: m_dow = val;
      4: m_date = val; 5: m_mon = val;  default: m_yr = val;
    endcase
  endtask

  task automatic do_write(input string req, input int fld, input int val);
    wr_en = 1'b1; wr_field = 3'(fld);
    wr_data = (fld == 2) ? enc_hour(val, m12) : bcd(val);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    put_field(fld, val);
    e_hr_roll = 0; e_dt_roll = 0;
    check_all(req);
  endtask

  task automatic set_all(input string req, input int yr, input int mon, input int dt,
                         input int dw, input int hr, input int mi, input int se);
    do_write(req, 4, 1);
    do_write(req, 6, yr); do_write(req, 5, mon); do_write(req, 4, dt);
    do_write(req, 3, dw); do_write(req, 2, hr); do_write(req, 1, mi); do_write(req, 0, se);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int r, fld, v;
    void'($urandom(32'd4242));
    m_sec = 0; m_min = 0; m_hr = 0; m_date = 1; m_mon = 1; m_yr = 0; m_dow = 0;
    m12 = 0; e_hr_roll = 0; e_dt_roll = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check_all("R12");

    do_tick("R1");
    // R8: latency, no change after first edge
    tick_1hz = 1'b1; @(posedge clk); @(negedge clk); tick_1hz = 1'b0;
    chk("R8", "sec early", rd_sec, bcd(m_sec));
    @(posedge clk); @(negedge clk); model_tick(); check_all("R8");

    // R2 R4 R7 R11: Apr 30 23:59:59 dow 6 -> May 1
    set_all("R9", 23, 4, 30, 6, 23, 59, 59);
    do_tick("R2");
    // R5 leap
    set_all("R9", 24, 2, 28, 2, 23, 59, 59);
    do_tick("R5");
    do_write("R9", 2, 23); do_write("R9", 1, 59); do_write("R9", 0, 59);
    do_tick("R5");
    set_all("R9", 23, 2, 28, 3, 23, 59, 59);
    do_tick("R5");
    // R6 century wrap
    set_all("R9", 99, 12, 31, 5, 23, 59, 59);
    do_tick("R6");
    // R3 twelve-hour
    fmt_12h = 1'b1; m12 = 1;
    do_write("R3", 2, 11); do_write("R3", 1, 59); do_write("R3", 0, 59);
    do_tick("R3");
    do_write("R3", 1, 59); do_write("R3", 0, 59);
    do_tick("R3");
    do_write("R3", 2, 23); do_write("R3", 1, 59); do_write("R3", 0, 59);
    do_tick("R3");
    fmt_12h = 1'b0; m12 = 0; do_write("R2", 2, m_hr);

    // R10: seconds write drops the pending tick
    do_write("R9", 0, 5);
    tick_1hz = 1'b1; @(posedge clk); @(negedge clk); tick_1hz = 1'b0;
    wr_en = 1'b1; wr_field = 3'd0; wr_data = bcd(30);
    @(posedge clk); @(negedge clk); wr_en = 1'b0; m_sec = 30;
    check_all("R10");
    @(posedge clk); @(negedge clk); check_all("R10");
    // R9: other write defers the tick
    tick_1hz = 1'b1; @(posedge clk); @(negedge clk); tick_1hz = 1'b0;
    wr_en = 1'b1; wr_field = 3'd1; wr_data = bcd(10);
    @(posedge clk); @(negedge clk); wr_en = 1'b0; m_min = 10;
    check_all("R9");
    @(posedge clk); @(negedge clk); model_tick(); check_all("R9");

    for (int i = 0; i < 400; i++) begin
      r = $urandom_range(0, 9);
      if (r <= 5) do_tick("R1");
      else if (r == 6) begin
        fld = $urandom_range(0, 6);
        case (fld)
          0, 1: v = $urandom_range(0, 59);
          2: v = $urandom_range(0, 23);
          3: v = $urandom_range(0, 6);
          4: v = $urandom_range(1, days_in(m_mon, m_yr));
          5: v = $urandom_range(1, 12);
          default: v = $urandom_range(0, 99);
        endcase
        if (fld == 5 && m_date > days_in(v, m_yr)) do_write("R9", 4, 1);
        if (fld == 6 && m_date > days_in(m_mon, v)) do_write("R9", 4, 1);
        do_write("R9", fld, v);
      end else if (r == 7) begin
        do_write("R1", 1, 59); do_write("R1", 0, $urandom_range(57, 59));
        if ($urandom_range(0, 1) == 1) do_write("R2", 2, 23);
      end else if (r == 8) begin
        m12 = ~m12; fmt_12h = m12;
        do_write("R3", 2, m_hr);
      end else begin
        v = $urandom_range(1, 12);
        do_write("R4", 4, 1); do_write("R4", 5, v);
        do_write("R4", 4, days_in(v, m_yr));
        do_write("R4", 2, 23); do_write("R4", 1, 59); do_write("R4", 0, 59);
        do_tick("R4");
      end
    end
    finish_run();
  end
endmodule